// File: doc/BRIEF.md
# Per-Core Interrupt Configuration Register Bank

This block holds the configuration and state of the 32 interrupts private to one core: 16 raised by software and 16 wired from private peripherals. For every interrupt it keeps a group bit, a group-modifier bit, enable, pending and active flags, an 8-bit priority and a trigger type. For each software interrupt it also keeps a 2-bit field that controls non-secure access. It also holds a sleep flag for the core and three bits that take interrupt groups out of participation. State is reached through a single-cycle register port with byte-lane strobes. Enable, pending and active are changed through paired set and clear words.

Every access carries a secure/non-secure attribute. While security is enabled, a non-secure agent sees only the interrupts whose effective group is non-secure group 1. Fields of all other interrupts read as zero and ignore its writes. The effective group of each interrupt is resolved from its modifier bit, its group bit and the global security-disable input. Priorities are shifted into the upper half of the range when a non-secure agent writes them, and shifted back when it reads them. The resolved groups, flags, priorities and trigger types are exported as flat vectors for a downstream arbiter.

Top module: `irq_bank_regs`

## Requirements
- R1: After reset the sleep flag is 1, and all enables, pending and active bits, priorities, group bits, modifier bits and access fields are 0. Peripheral interrupts reset to level-sensitive.
- R2: A write to a set word ORs the written ones into the state, and a write to a clear word removes them. Zeros have no effect. A read of either word of a pair returns the current state. The read data appears in the cycle after the request.
- R3: In the bit-per-interrupt words, write strobe bit k covers data bits 8k+7..8k. Unstrobed lanes leave their state unchanged.
- R4: With security disabled, group bit 0 gives group code 0 (secure group 0) and 1 gives code 1 (non-secure group 1). With security enabled, {modifier, group} 00 gives code 0, 01 gives code 1, 10 gives code 2 (secure group 1) and 11 gives code 1. Interrupt n's code sits at o_eff_grp[2n+1:2n].
- R5: With security enabled, a non-secure access reads zero for, and does not change, any per-interrupt field of an interrupt whose group code is not 1.
- R6: A non-secure write of value v to an eligible priority byte stores 0x80 | (v >> 1). A non-secure read of it returns (stored << 1) & 0xFF. Secure accesses, and all accesses while security is disabled, store and return v unchanged. Priority byte n sits at byte address 0x40+n.
- R7: The configuration words hold 2 bits per interrupt. Bit 2i+1 is 1 for edge-triggered and bit 2i reads 0. The low word (0x28, interrupts 0–15) always reads edge and ignores writes. The high word (0x2C, interrupts 16–31) is writable.
- R8: With security enabled, non-secure reads of the group word (0x08) and the wake word (0x04) return zero, and non-secure writes to them are ignored.
- R9: The modifier word (0x0C) and the access-control word (0x30) read zero and ignore writes for every non-secure access and whenever security is disabled. The access-control field of software interrupt n sits at bits 2n+1..2n. The stored values survive a period with security disabled.
- R10: The wake word: writing bit 0 sets or clears the sleep flag. While the core sleeps, a read returns bit 0 (sleeping) and bit 1 (children asleep) both set. Otherwise it returns 0.
- R11: An access to an undecoded or misaligned address returns zero read data and raises rsp_err in the response cycle, and changes no state.
- R12: The control word (0x00) bits 2..0 hold the group-participation disables and drive o_grp_dis. They change only on a write to that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_disable | input | 1 | Security disabled globally |
| req_valid | input | 1 | Access request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_secure | input | 1 | Access comes from the secure state |
| req_addr | input | 7 | Byte address |
| req_wdata | input | 32 | Write data |
| req_wstrb | input | 4 | Byte-lane write strobes |
| rsp_rdata | output | 32 | Read data, one cycle after the request |
| rsp_err | output | 1 | Undecoded or misaligned access, one cycle after the request |
| o_enable | output | 32 | Enable flags |
| o_pending | output | 32 | Pending flags |
| o_active | output | 32 | Active flags |
| o_edge | output | 32 | 1 = edge-triggered |
| o_prio | output | 256 | Priority bytes, interrupt n at bits 8n+7..8n |
| o_eff_grp | output | 64 | Resolved group codes |
| o_sleep | output | 1 | Core marked in low power |
| o_grp_dis | output | 3 | Group-participation disables |

## Verification
A wrong group resolution shows up first on o_eff_grp in the cycle after the group or modifier write. It then spreads to every non-secure access: whole words of flags read back with bits missing or extra, and writes land on interrupts they should not touch. The next read of the affected word exposes these, one cycle after it is issued. A broken priority shift shows as a byte on o_prio without its top bit after a non-secure write, and as a secure/non-secure read pair that fails to differ by one bit position. A set or clear word that behaves as a plain store appears at once as lost flags in the next read of the pair.

// File: rtl/irq_bank_pkg.sv
package irq_bank_pkg;

  typedef enum logic [1:0] {
    GRP_S0  = 2'd0,
    GRP_NS1 = 2'd1,
    GRP_S1  = 2'd2
  } grp_e;

  // Word offsets (byte address / 4)
  localparam int W_CTRL  = 0;
  localparam int W_WAKE  = 1;
  localparam int W_GROUP = 2;
  localparam int W_MOD   = 3;
  localparam int W_SETEN = 4;
  localparam int W_CLREN = 5;
  localparam int W_SETPD = 6;
  localparam int W_CLRPD = 7;
  localparam int W_SETAC = 8;
  localparam int W_CLRAC = 9;
  localparam int W_CFGLO = 10;
  localparam int W_CFGHI = 11;
  localparam int W_NSAC  = 12;
  localparam int W_PRIO  = 16;

  function automatic logic [31:0] lane_mask(input logic [3:0] strb);
    logic [31:0] m;
    for (int k = 0; k < 4; k++) m[8*k +: 8] = {8{strb[k]}};
    return m;
  endfunction

endpackage

// File: rtl/irq_group_resolve.sv
module irq_group_resolve
  import irq_bank_pkg::*;
#(
  parameter int NIRQ = 32
) (
  input  logic [NIRQ-1:0]   grp,
  input  logic [NIRQ-1:0]   mod,
  input  logic              sec_dis,
  output logic [2*NIRQ-1:0] eff,
  output logic [NIRQ-1:0]   ns1
);
  for (genvar g = 0; g < NIRQ; g++) begin : g_irq
    grp_e code;
    always_comb begin
      if (sec_dis) begin
        code = grp[g] ? GRP_NS1 : GRP_S0;
      end else begin
        case ({mod[g], grp[g]})
          2'b00:   code = GRP_S0;
          2'b10:   code = GRP_S1;
          default: code = GRP_NS1;
        endcase
      end
    end
    assign eff[2*g +: 2] = code;
    assign ns1[g]        = (code == GRP_NS1);
  end
endmodule

// File: rtl/irq_setclr_vec.sv
module irq_setclr_vec #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         set_en,
  input  logic         clr_en,
  input  logic [W-1:0] bits,
  output logic [W-1:0] q
);
  logic [W-1:0] q_d;
  logic         upd;

  assign upd = set_en | clr_en;

  always_comb begin
    q_d = q;
    if (set_en) q_d = q | bits;
    if (clr_en) q_d = q & ~bits;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= '0;
    else if (upd) q <= q_d;
  end
endmodule

// File: rtl/irq_prio_bank.sv
module irq_prio_bank #(
  parameter int NIRQ   = 32,
  parameter int PRIO_W = 8,
  parameter int WORD_W = 32,
  parameter int SEL_W  = $clog2(NIRQ*PRIO_W/WORD_W)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [SEL_W-1:0]         sel,
  input  logic [WORD_W/PRIO_W-1:0] wstrb,
  input  logic [WORD_W-1:0]        wdata,
  input  logic                     ns_xform,
  input  logic [NIRQ-1:0]          lane_ok,
  output logic [WORD_W-1:0]        rd_data,
  output logic [NIRQ*PRIO_W-1:0]   prio
);
  localparam int LANES = WORD_W / PRIO_W;

  logic [NIRQ*PRIO_W-1:0] prio_d;

  always_comb begin
    prio_d = prio;
    for (int n = 0; n < NIRQ; n++) begin
      if ((int'(sel) == n / LANES) && wstrb[n % LANES] && lane_ok[n]) begin
        if (ns_xform)
          prio_d[n*PRIO_W +: PRIO_W] = {1'b1, wdata[(n % LANES)*PRIO_W + 1 +: PRIO_W-1]};
        else
          prio_d[n*PRIO_W +: PRIO_W] = wdata[(n % LANES)*PRIO_W +: PRIO_W];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     prio <= '0;
    else if (wr_en) prio <= prio_d;
  end

  always_comb begin
    rd_data = '0;
    for (int l = 0; l < LANES; l++) begin
      int idx;
      logic [PRIO_W-1:0] p;
      idx = int'(sel) * LANES + l;
      p   = prio[idx*PRIO_W +: PRIO_W];
      if (lane_ok[idx])
        rd_data[l*PRIO_W +: PRIO_W] = ns_xform ? {p[PRIO_W-2:0], 1'b0} : p;
    end
  end
endmodule

// File: rtl/irq_bank_regs.sv
module irq_bank_regs
  import irq_bank_pkg::*;
#(
  parameter int N_SGI  = 16,
  parameter int N_PPI  = 16,
  parameter int PRIO_W = 8,
  parameter int ADDR_W = 7
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              sec_disable,
  input  logic                              req_valid,
  input  logic                              req_write,
  input  logic                              req_secure,
  input  logic [ADDR_W-1:0]                 req_addr,
  input  logic [31:0]                       req_wdata,
  input  logic [3:0]                        req_wstrb,
  output logic [31:0]                       rsp_rdata,
  output logic                              rsp_err,
  output logic [N_SGI+N_PPI-1:0]            o_enable,
  output logic [N_SGI+N_PPI-1:0]            o_pending,
  output logic [N_SGI+N_PPI-1:0]            o_active,
  output logic [N_SGI+N_PPI-1:0]            o_edge,
  output logic [(N_SGI+N_PPI)*PRIO_W-1:0]   o_prio,
  output logic [2*(N_SGI+N_PPI)-1:0]        o_eff_grp,
  output logic                              o_sleep,
  output logic [2:0]                        o_grp_dis
);
  localparam int NIRQ   = N_SGI + N_PPI;
  localparam int WORD_W = 32;
  localparam int PWORDS = NIRQ * PRIO_W / WORD_W;
  localparam int SEL_W  = $clog2(PWORDS);
  localparam int WSEL_W = ADDR_W - 2;

  logic [WSEL_W-1:0] word;
  logic              aligned, wr, ns_gate, sec_ok, is_prio, hit;
  logic [31:0]       bmask, wbits, rd, prio_rd;
  logic [NIRQ-1:0]   ns1, lane_ok, grp_q, grp_d, mod_q, mod_d;
  logic [2*N_SGI-1:0] nsac_q, nsac_d;
  logic [N_PPI-1:0]  edge_q, edge_d;
  logic              sleep_q, sleep_d;
  logic [2:0]        dis_q, dis_d;
  logic              we_grp, we_mod, we_nsac, we_edge, we_sleep, we_dis;
  logic [SEL_W-1:0]  prio_sel;

  // Access decode and security gating
  assign word     = req_addr[ADDR_W-1:2];
  assign aligned  = (req_addr[1:0] == 2'b00);
  assign wr       = req_valid & req_write & aligned;
  assign ns_gate  = ~sec_disable & ~req_secure;
  assign sec_ok   = ~sec_disable & req_secure;
  assign lane_ok  = ns_gate ? ns1 : '1;
  assign bmask    = lane_mask(req_wstrb);
  assign wbits    = req_wdata & bmask & lane_ok;
  assign is_prio  = (int'(word) >= W_PRIO) && (int'(word) < W_PRIO + PWORDS);
  assign prio_sel = SEL_W'(int'(word) - W_PRIO);

  irq_group_resolve #(.NIRQ(NIRQ)) u_grp (
    .grp(grp_q), .mod(mod_q), .sec_dis(sec_disable), .eff(o_eff_grp), .ns1(ns1)
  );

  irq_setclr_vec #(.W(NIRQ)) u_en (
    .clk(clk), .rst_n(rst_n),
    .set_en(wr && int'(word) == W_SETEN), .clr_en(wr && int'(word) == W_CLREN),
    .bits(wbits), .q(o_enable)
  );
  irq_setclr_vec #(.W(NIRQ)) u_pd (
    .clk(clk), .rst_n(rst_n),
    .set_en(wr && int'(word) == W_SETPD), .clr_en(wr && int'(word) == W_CLRPD),
    .bits(wbits), .q(o_pending)
  );
  irq_setclr_vec #(.W(NIRQ)) u_ac (
    .clk(clk), .rst_n(rst_n),
    .set_en(wr && int'(word) == W_SETAC), .clr_en(wr && int'(word) == W_CLRAC),
    .bits(wbits), .q(o_active)
  );

  irq_prio_bank #(.NIRQ(NIRQ), .PRIO_W(PRIO_W), .WORD_W(WORD_W), .SEL_W(SEL_W)) u_prio (
    .clk(clk), .rst_n(rst_n), .wr_en(wr && is_prio), .sel(prio_sel),
    .wstrb(req_wstrb), .wdata(req_wdata), .ns_xform(ns_gate), .lane_ok(lane_ok),
    .rd_data(prio_rd), .prio(o_prio)
  );

  // Next-state for whole-word and configuration fields
  assign we_grp   = wr && int'(word) == W_GROUP && !ns_gate;
  assign we_mod   = wr && int'(word) == W_MOD   && sec_ok;
  assign we_nsac  = wr && int'(word) == W_NSAC  && sec_ok;
  assign we_edge  = wr && int'(word) == W_CFGHI;
  assign we_sleep = wr && int'(word) == W_WAKE  && !ns_gate && req_wstrb[0];
  assign we_dis   = wr && int'(word) == W_CTRL  && req_wstrb[0];

  assign grp_d   = (grp_q  & ~bmask) | (req_wdata & bmask);
  assign mod_d   = (mod_q  & ~bmask) | (req_wdata & bmask);
  assign nsac_d  = (nsac_q & ~bmask) | (req_wdata & bmask);
  assign sleep_d = req_wdata[0];
  assign dis_d   = req_wdata[2:0];

  always_comb begin
    edge_d = edge_q;
    for (int i = 0; i < N_PPI; i++)
      if (lane_ok[N_SGI+i] && bmask[2*i+1]) edge_d[i] = req_wdata[2*i+1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grp_q   <= '0;
      mod_q   <= '0;
      nsac_q  <= '0;
      edge_q  <= '0;
      sleep_q <= 1'b1;
      dis_q   <= '0;
    end else begin
      if (we_grp)   grp_q   <= grp_d;
      if (we_mod)   mod_q   <= mod_d;
      if (we_nsac)  nsac_q  <= nsac_d;
      if (we_edge)  edge_q  <= edge_d;
      if (we_sleep) sleep_q <= sleep_d;
      if (we_dis)   dis_q   <= dis_d;
    end
  end

  // Read multiplexer
  always_comb begin
    rd  = '0;
    hit = 1'b1;
    case (int'(word))
      W_CTRL:  rd[2:0] = dis_q;
      W_WAKE:  rd[1:0] = ns_gate ? 2'b00 : {sleep_q, sleep_q};
      W_GROUP: rd = ns_gate ? '0 : grp_q;
      W_MOD:   rd = sec_ok ? mod_q : '0;
      W_SETEN, W_CLREN: rd = o_enable  & lane_ok;
      W_SETPD, W_CLRPD: rd = o_pending & lane_ok;
      W_SETAC, W_CLRAC: rd = o_active  & lane_ok;
      W_CFGLO: for (int i = 0; i < N_SGI; i++) rd[2*i+1] = lane_ok[i];
      W_CFGHI: for (int i = 0; i < N_PPI; i++) rd[2*i+1] = edge_q[i] & lane_ok[N_SGI+i];
      W_NSAC:  rd = sec_ok ? nsac_q : '0;
      default: begin
        if (is_prio) rd = prio_rd;
        else         hit = 1'b0;
      end
    endcase
    if (!aligned) begin
      rd  = '0;
      hit = 1'b0;
    end
  end

  // Registered response
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_rdata <= (req_valid && !req_write) ? rd : '0;
      rsp_err   <= req_valid && !hit;
    end
  end

  assign o_edge    = {edge_q, {N_SGI{1'b1}}};
  assign o_sleep   = sleep_q;
  assign o_grp_dis = dis_q;
endmodule

// File: rtl/irq_bank_regs_chk.sv
module irq_bank_regs_chk
  import irq_bank_pkg::*;
#(
  parameter int N_SGI  = 16,
  parameter int N_PPI  = 16,
  parameter int PRIO_W = 8,
  parameter int ADDR_W = 7
) (
  input logic                              clk,
  input logic                              rst_n,
  input logic                              sec_disable,
  input logic                              req_valid,
  input logic                              req_write,
  input logic                              req_secure,
  input logic [ADDR_W-1:0]                 req_addr,
  input logic [31:0]                       rsp_rdata,
  input logic                              rsp_err,
  input logic [N_SGI+N_PPI-1:0]            o_enable,
  input logic [N_SGI+N_PPI-1:0]            o_pending,
  input logic [N_SGI+N_PPI-1:0]            o_active,
  input logic [N_SGI+N_PPI-1:0]            o_edge,
  input logic [(N_SGI+N_PPI)*PRIO_W-1:0]   o_prio,
  input logic [2*(N_SGI+N_PPI)-1:0]        o_eff_grp,
  input logic [2:0]                        o_grp_dis
);
  localparam int NIRQ = N_SGI + N_PPI;

  logic                   wr_any, ns_wr, ns_wr_d, prio_bad;
  logic [NIRQ-1:0]        elig;
  logic [NIRQ*PRIO_W-1:0] prio_d;
  logic [ADDR_W-3:0]      word;

  assign word   = req_addr[ADDR_W-1:2];
  assign wr_any = req_valid & req_write;
  assign ns_wr  = wr_any & ~sec_disable & ~req_secure;

  always_comb
    for (int i = 0; i < NIRQ; i++) elig[i] = (o_eff_grp[2*i +: 2] == GRP_NS1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ns_wr_d <= 1'b0;
      prio_d  <= '0;
    end else begin
      ns_wr_d <= ns_wr;
      prio_d  <= o_prio;
    end
  end

  always_comb begin
    prio_bad = 1'b0;
    for (int n = 0; n < NIRQ; n++)
      if (o_prio[n*PRIO_W +: PRIO_W] != prio_d[n*PRIO_W +: PRIO_W] &&
          !o_prio[n*PRIO_W + PRIO_W - 1])
        prio_bad = 1'b1;
  end

  // R11
  undec_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> (rsp_rdata == '0));

  // R2
  no_write_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_any |=> ($stable(o_enable) && $stable(o_pending) && $stable(o_active)));

  // R2
  set_only_grows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_any && int'(word) == W_SETEN) |=> ((o_enable & $past(o_enable)) == $past(o_enable)));

  // R5
  ns_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ns_wr |=> ((((o_enable ^ $past(o_enable)) | (o_pending ^ $past(o_pending)) |
                 (o_active ^ $past(o_active))) & ~$past(elig)) == '0));

  // R6
  ns_prio_msb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ns_wr_d |-> !prio_bad);

  // R12
  ctrl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_any && int'(word) == W_CTRL) |=> $stable(o_grp_dis));

  // R7
  cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_any && int'(word) == W_CFGHI) |=> $stable(o_edge));
endmodule

bind irq_bank_regs irq_bank_regs_chk #(
  .N_SGI(N_SGI), .N_PPI(N_PPI), .PRIO_W(PRIO_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sec_disable(sec_disable), .req_valid(req_valid),
  .req_write(req_write), .req_secure(req_secure), .req_addr(req_addr),
  .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .o_enable(o_enable),
  .o_pending(o_pending), .o_active(o_active), .o_edge(o_edge), .o_prio(o_prio),
  .o_eff_grp(o_eff_grp), .o_grp_dis(o_grp_dis)
);

// File: tb/irq_bank_regs_tb.sv
module irq_bank_regs_tb;
  logic         clk, rst_n, sec_disable;
  logic         req_valid, req_write, req_secure;
  logic [6:0]   req_addr;
  logic [31:0]  req_wdata;
  logic [3:0]   req_wstrb;
  logic [31:0]  rsp_rdata;
  logic         rsp_err;
  logic [31:0]  o_enable, o_pending, o_active, o_edge;
  logic [255:0] o_prio;
  logic [63:0]  o_eff_grp;
  logic         o_sleep;
  logic [2:0]   o_grp_dis;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  irq_bank_regs u_dut (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  localparam bit S = 1'b1, NS = 1'b0;

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge with the response registered.
  task automatic acc(input bit w, input bit sec, input logic [6:0] a,
                     input logic [31:0] d, input logic [3:0] s);
    req_valid = 1'b1; req_write = w; req_secure = sec;
    req_addr = a; req_wdata = d; req_wstrb = s;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic wr(input bit sec, input logic [6:0] a, input logic [31:0] d);
    acc(1'b1, sec, a, d, 4'hF);
  endtask

  task automatic rd(input bit sec, input logic [6:0] a, input string tag, input logic [31:0] exp);
    acc(1'b0, sec, a, 32'h0, 4'h0);
    chk(tag, {32'h0, rsp_rdata}, {32'h0, exp});
  endtask

  task automatic t_reset;
    chk("R1 sleep flag", {63'h0, o_sleep}, 64'h1);
    chk("R1 priorities zero", {63'h0, |o_prio}, 64'h0);
    chk("R1 peripheral level", {32'h0, o_edge}, 64'h0000_FFFF);
    rd(S, 7'h04, "R10 wake after reset", 32'h3);
    rd(S, 7'h10, "R1 enables zero", 32'h0);
    rd(S, 7'h18, "R1 pending zero", 32'h0);
    rd(S, 7'h30, "R1 access fields zero", 32'h0);
  endtask

  task automatic t_setclr;
    wr(S, 7'h10, 32'h0000_00F0);
    wr(S, 7'h10, 32'h0000_0003);
    rd(S, 7'h10, "R2 set accumulates", 32'h0000_00F3);
    wr(S, 7'h14, 32'h0000_0010);
    rd(S, 7'h14, "R2 clear word reads state", 32'h0000_00E3);
    rd(S, 7'h10, "R2 set word reads state", 32'h0000_00E3);
    chk("R2 enable port", {32'h0, o_enable}, {32'h0, 32'h0000_00E3});
    acc(1'b1, S, 7'h10, 32'hFFFF_FFFF, 4'b0100);
    rd(S, 7'h10, "R3 strobe lane 2 only", 32'h00FF_00E3);
    wr(S, 7'h14, 32'hFFFF_FFFF);
    rd(S, 7'h10, "R2 clear all", 32'h0);
  endtask

  task automatic t_group;
    wr(S, 7'h08, 32'hFF00_FF00);
    wr(S, 7'h0C, 32'hFFFF_0000);
    chk("R4 mod0 grp0 -> 0", {62'h0, o_eff_grp[1:0]}, 64'd0);
    chk("R4 mod0 grp1 -> 1", {62'h0, o_eff_grp[17:16]}, 64'd1);
    chk("R4 mod1 grp0 -> 2", {62'h0, o_eff_grp[33:32]}, 64'd2);
    chk("R4 mod1 grp1 -> 1", {62'h0, o_eff_grp[49:48]}, 64'd1);
    rd(S, 7'h0C, "R9 secure modifier read", 32'hFFFF_0000);
  endtask

  task automatic t_gating;
    wr(S, 7'h18, 32'h0F0F_0F0F);
    rd(NS, 7'h18, "R5 ns pending read masked", 32'h0F00_0F00);
    wr(NS, 7'h1C, 32'hFFFF_FFFF);
    rd(S, 7'h18, "R5 ns clear limited", 32'h000F_000F);
    wr(NS, 7'h20, 32'hFFFF_FFFF);
    rd(S, 7'h24, "R5 ns set active limited", 32'hFF00_FF00);
    rd(NS, 7'h08, "R8 ns group reads zero", 32'h0);
    wr(NS, 7'h08, 32'h0);
    rd(S, 7'h08, "R8 ns group write ignored", 32'hFF00_FF00);
    rd(NS, 7'h04, "R8 ns wake reads zero", 32'h0);
    wr(NS, 7'h04, 32'h0);
    chk("R8 ns wake write ignored", {63'h0, o_sleep}, 64'h1);
  endtask

  task automatic t_prio;
    wr(S, 7'h40, 32'h4433_2211);
    rd(S, 7'h40, "R6 secure priority plain", 32'h4433_2211);
    rd(NS, 7'h40, "R6 ns read of secure irqs", 32'h0);
    acc(1'b1, NS, 7'h48, 32'h8060_4020, 4'b0011);
    rd(S, 7'h48, "R6 ns write shifted", 32'h0000_A090);
    chk("R6 priority port irq9", {56'h0, o_prio[79:72]}, 64'hA0);
    rd(NS, 7'h48, "R6 ns read shifted back", 32'h0000_4020);
    wr(NS, 7'h40, 32'hFFFF_FFFF);
    rd(S, 7'h40, "R5 ns priority write ignored", 32'h4433_2211);
  endtask

  task automatic t_cfg;
    wr(S, 7'h28, 32'h0);
    rd(S, 7'h28, "R7 low word fixed edge", 32'hAAAA_AAAA);
    wr(S, 7'h2C, 32'hFFFF_FFFF);
    rd(S, 7'h2C, "R7 high word odd bits only", 32'hAAAA_AAAA);
    rd(NS, 7'h2C, "R7 ns high word masked", 32'hAAAA_0000);
    wr(NS, 7'h2C, 32'h0);
    rd(S, 7'h2C, "R7 ns high write limited", 32'h0000_AAAA);
    chk("R7 edge port", {32'h0, o_edge}, {32'h0, 32'h00FF_FFFF});
  endtask

  task automatic t_nsac;
    wr(S, 7'h30, 32'h0000_00E4);
    rd(S, 7'h30, "R9 access field packing", 32'h0000_00E4);
    rd(NS, 7'h30, "R9 ns access read zero", 32'h0);
    wr(NS, 7'h30, 32'h0);
    rd(S, 7'h30, "R9 ns access write ignored", 32'h0000_00E4);
    rd(NS, 7'h0C, "R9 ns modifier read zero", 32'h0);
    sec_disable = 1'b1;
    rd(S, 7'h30, "R9 access zero when disabled", 32'h0);
    rd(S, 7'h0C, "R9 modifier zero when disabled", 32'h0);
    wr(S, 7'h0C, 32'h0);
    chk("R4 disabled grp0 -> 0", {62'h0, o_eff_grp[33:32]}, 64'd0);
    chk("R4 disabled grp1 -> 1", {62'h0, o_eff_grp[17:16]}, 64'd1);
    rd(NS, 7'h18, "R5 ns sees all when disabled", 32'h000F_000F);
    rd(NS, 7'h40, "R6 no shift when disabled", 32'h4433_2211);
    sec_disable = 1'b0;
    rd(S, 7'h0C, "R9 modifier kept", 32'hFFFF_0000);
  endtask

  task automatic t_wake_ctrl;
    wr(S, 7'h04, 32'h0);
    chk("R10 sleep cleared", {63'h0, o_sleep}, 64'h0);
    rd(S, 7'h04, "R10 awake reads zero", 32'h0);
    wr(S, 7'h04, 32'h1);
    rd(S, 7'h04, "R10 sleep reads both flags", 32'h3);
    wr(S, 7'h00, 32'h5);
    chk("R12 disable port", {61'h0, o_grp_dis}, 64'h5);
    rd(S, 7'h00, "R12 control read", 32'h5);
  endtask

  task automatic t_undec;
    acc(1'b0, S, 7'h7C, 32'h0, 4'h0);
    chk("R11 undecoded data", {32'h0, rsp_rdata}, 64'h0);
    chk("R11 undecoded err", {63'h0, rsp_err}, 64'h1);
    acc(1'b1, S, 7'h12, 32'hFFFF_FFFF, 4'hF);
    chk("R11 misaligned err", {63'h0, rsp_err}, 64'h1);
    rd(S, 7'h10, "R11 misaligned write ignored", 32'h0);
    chk("R11 err clears", {63'h0, rsp_err}, 64'h0);
  endtask

  initial begin
    rst_n = 1'b0; sec_disable = 1'b0;
    req_valid = 1'b0; req_write = 1'b0; req_secure = 1'b0;
    req_addr = '0; req_wdata = '0; req_wstrb = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_setclr();
    t_group();
    t_gating();
    t_prio();
    t_cfg();
    t_nsac();
    t_wake_ctrl();
    t_undec();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      done = 1;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule